// File: doc/BRIEF.md
# Interrupt Source Trigger Detector

This block is the per-source front end of an interrupt controller. It takes a vector of raw interrupt lines, resynchronizes them, and keeps one pending flag per source. Each source watches its input in one of four sense modes: high level, falling edge, rising edge, or any edge. Most sources have a sense fixed when the block is elaborated. A parameter names the sources that are level sensitive, and every other fixed source is rising-edge. A contiguous window of external-pin sources instead holds its sense in a byte-wide mode register that software can rewrite.

A downstream dispatcher reads the flag vector, chooses which source to request, and tells this block which source is currently outstanding. Software can clear a pending edge flag by writing zero to that source's flag register. The dispatcher's acknowledge clears the flag of an edge source. If an outstanding level-sensitive source drops its input, the block raises a withdraw event so that the dispatcher can retract the request and free its slot.

Top module: `irq_sense_front`

## Requirements
- R1: After reset all flags read 0. A fixed source listed in `LEVEL_SRCS` is level sensitive and every other fixed source is rising-edge. Each external mode register reads 0x00 if its source is listed and 0x08 otherwise.
- R2: Each raw input passes through two flip-flops. A change on `irq_in` is visible in `flags_o` at the third rising clock edge after it.
- R3: In level mode (code 0), the flag takes the synchronized input value on every clock. It sets while the input is high and clears when the input is low.
- R4: In edge modes the flag sets when the synchronized input and the stored previous level show the selected transition: code 1 falling, code 2 rising, code 3 either. The stored level resets to 0 and is refreshed every clock.
- R5: A flag-register write with data 0 clears the flag of an edge-mode source. The same write has no effect on a level-mode source. A write with nonzero data never sets or changes any flag.
- R6: An acknowledge clears the named source's flag when that source is edge-triggered and leaves it unchanged when it is level-triggered.
- R7: `withdraw_o` is high during the cycle in which the outstanding request (`cur_req_valid`, `cur_req_idx`) is a level source whose flag is set and whose synchronized input is low. The flag clears at the next edge. `withdraw_o` is never high for an edge-mode source.
- R8: Sources `EXT_BASE` to `EXT_BASE+EXT_COUNT-1` take their mode from a byte register. A write loads bits 3:2 as the mode and ignores all other bits. A read returns the mode in bits 3:2, with every other bit 0.
- R9: Changing a source's mode does not change a flag that is already set.
- R10: A flag-register read returns the flag in bit 0, with bits 7:1 at 0.
- R11: When an edge event and a clear (software write of 0 or acknowledge) hit the same source in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt lines |
| flag_wr_en | input | 1 | Flag register write strobe |
| flag_wr_idx | input | IDX_W | Source number written |
| flag_wr_data | input | 8 | Write data; only 0 acts, as a clear |
| flag_rd_idx | input | IDX_W | Source number read |
| flag_rd_data | output | 8 | Flag of the selected source in bit 0 |
| ack_en | input | 1 | Acknowledge strobe from the dispatcher |
| ack_idx | input | IDX_W | Source being acknowledged |
| cur_req_valid | input | 1 | A request is outstanding |
| cur_req_idx | input | IDX_W | Source of the outstanding request |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_idx | input | EXT_W | External source offset written |
| mode_wr_data | input | 8 | Mode byte, mode in bits 3:2 |
| mode_rd_idx | input | EXT_W | External source offset read |
| mode_rd_data | output | 8 | Mode byte of the selected external source |
| flags_o | output | NUM_SRC | Pending flag vector |
| withdraw_o | output | 1 | Outstanding level request is withdrawn |

## Verification
The bound checker watches every source on every cycle. It checks that level-mode flags copy the synchronized input, that an edge-mode flag rises only after a detected edge, and that every detected edge leaves its flag set. It also checks that no edge is reported in level mode, that a withdraw event is followed by a cleared flag, and that unused read-data bits stay 0. Several behaviours appear only in the bench's scenarios: the three-edge latency, the rule for which writes and acknowledges are ignored, the priority of an event over a same-cycle clear, a mode rewrite that keeps a pending flag, and the reset image of the mode registers.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'd0,
    SENSE_FALL  = 2'd1,
    SENSE_RISE  = 2'd2,
    SENSE_BOTH  = 2'd3
  } sense_t;

  localparam int MODE_LSB = 2;

  // Edge event for one source given its previous and current synchronized level.
  function automatic logic edge_hit(sense_t m, logic prev, logic cur);
    case (m)
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      SENSE_BOTH: return prev ^ cur;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] pack_mode(logic [1:0] m);
    return {4'b0000, m, 2'b00};
  endfunction

  function automatic logic [1:0] unpack_mode(logic [7:0] d);
    return d[MODE_LSB +: 2];
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irq_mode_bank.sv
module irq_mode_bank
  import irq_sense_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int EXT_BASE = 64,
  parameter int EXT_COUNT = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_SRCS = '0,
  localparam int EXT_W = $clog2(EXT_COUNT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [EXT_W-1:0]            wr_idx,
  input  logic [7:0]                  wr_data,
  input  logic [EXT_W-1:0]            rd_idx,
  output logic [7:0]                  rd_data,
  output logic [EXT_COUNT-1:0][1:0]   modes_o
);
  logic [EXT_COUNT-1:0][1:0] modes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < EXT_COUNT; k++) begin
        modes[k] <= LEVEL_SRCS[EXT_BASE + k] ? SENSE_LEVEL : SENSE_RISE;
      end
    end else if (wr_en && (int'(wr_idx) < EXT_COUNT)) begin
      modes[wr_idx] <= unpack_mode(wr_data);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(rd_idx) < EXT_COUNT) rd_data = pack_mode(modes[rd_idx]);
  end

  assign modes_o = modes;
endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
  import irq_sense_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       hit_o
);
  logic   prev;
  sense_t m;

  assign m     = sense_t'(mode_i);
  assign hit_o = edge_hit(m, prev, lvl_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      prev <= lvl_i;
      if (m == SENSE_LEVEL)  flag_o <= lvl_i;
      else if (hit_o)        flag_o <= 1'b1;
      else if (clr_i)        flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_sense_front.sv
module irq_sense_front
  import irq_sense_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int EXT_BASE = 64,
  parameter int EXT_COUNT = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_SRCS =
    ({{(NUM_SRC-1){1'b0}}, 1'b1} << 3) | ({{(NUM_SRC-1){1'b0}}, 1'b1} << 66),
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int EXT_W = $clog2(EXT_COUNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               flag_wr_en,
  input  logic [IDX_W-1:0]   flag_wr_idx,
  input  logic [7:0]         flag_wr_data,
  input  logic [IDX_W-1:0]   flag_rd_idx,
  output logic [7:0]         flag_rd_data,
  input  logic               ack_en,
  input  logic [IDX_W-1:0]   ack_idx,
  input  logic               cur_req_valid,
  input  logic [IDX_W-1:0]   cur_req_idx,
  input  logic               mode_wr_en,
  input  logic [EXT_W-1:0]   mode_wr_idx,
  input  logic [7:0]         mode_wr_data,
  input  logic [EXT_W-1:0]   mode_rd_idx,
  output logic [7:0]         mode_rd_data,
  output logic [NUM_SRC-1:0] flags_o,
  output logic               withdraw_o
);
  function automatic logic pick(logic [NUM_SRC-1:0] v, logic [IDX_W-1:0] i);
    return (int'(i) < NUM_SRC) ? v[i] : 1'b0;
  endfunction

  logic [NUM_SRC-1:0]        lvl_sync;
  logic [NUM_SRC-1:0]        hit_vec;
  logic [NUM_SRC-1:0]        lvl_mask;
  logic [NUM_SRC-1:0]        clr_vec;
  logic [NUM_SRC-1:0][1:0]   mode_vec;
  logic [EXT_COUNT-1:0][1:0] ext_modes;
  logic                      sw_clear;

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl_sync)
  );

  irq_mode_bank #(
    .NUM_SRC(NUM_SRC), .EXT_BASE(EXT_BASE), .EXT_COUNT(EXT_COUNT), .LEVEL_SRCS(LEVEL_SRCS)
  ) u_modes (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mode_wr_en), .wr_idx(mode_wr_idx), .wr_data(mode_wr_data),
    .rd_idx(mode_rd_idx), .rd_data(mode_rd_data), .modes_o(ext_modes)
  );

  assign sw_clear = flag_wr_en && (flag_wr_data == 8'h00);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i >= EXT_BASE && i < EXT_BASE + EXT_COUNT) begin : g_ext
      assign mode_vec[i] = ext_modes[i - EXT_BASE];
    end else begin : g_fixed
      assign mode_vec[i] = LEVEL_SRCS[i] ? SENSE_LEVEL : SENSE_RISE;
    end

    assign lvl_mask[i] = (mode_vec[i] == SENSE_LEVEL);
    assign clr_vec[i]  = (sw_clear && flag_wr_idx == IDX_W'(i)) ||
                         (ack_en && ack_idx == IDX_W'(i));

    irq_sense_cell u_cell (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync[i]), .mode_i(mode_vec[i]),
      .clr_i(clr_vec[i]), .flag_o(flags_o[i]), .hit_o(hit_vec[i])
    );
  end

  assign flag_rd_data = {7'b0000000, pick(flags_o, flag_rd_idx)};

  assign withdraw_o = cur_req_valid && pick(lvl_mask, cur_req_idx) &&
                      pick(flags_o, cur_req_idx) && !pick(lvl_sync, cur_req_idx);
endmodule

// File: rtl/irq_sense_front_chk.sv
module irq_sense_front_chk #(
  parameter int NUM_SRC = 96,
  parameter int IDX_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] flags_o,
  input logic [NUM_SRC-1:0] lvl_sync,
  input logic [NUM_SRC-1:0] lvl_mask,
  input logic [NUM_SRC-1:0] hit_vec,
  input logic               withdraw_o,
  input logic [IDX_W-1:0]   cur_req_idx,
  input logic [7:0]         flag_rd_data,
  input logic [7:0]         mode_rd_data
);
  // R3: level-mode flags copy the synchronized input one clock later
  a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(lvl_mask)) == ($past(lvl_sync) & $past(lvl_mask))));

  // R4: an edge-mode flag only rises after a detected edge
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(lvl_mask) & ~$past(hit_vec)) == '0));

  // R11: every detected edge leaves its flag set, whatever clear arrives with it
  a_r11_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((flags_o & $past(hit_vec)) == $past(hit_vec)));

  // R4: no edge events in level mode
  a_r4_no_hit_in_level: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & lvl_mask) == '0);

  // R7: a withdrawn request has its flag cleared at the next edge
  a_r7_withdraw_clears: assert property (@(posedge clk) disable iff (!rst_n)
    withdraw_o |=> (flags_o[$past(cur_req_idx)] == 1'b0));

  // R10: flag reads carry data in bit 0 only
  a_r10_flag_read: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_data[7:1] == 7'd0);

  // R8: mode reads carry data in bits 3:2 only
  a_r8_mode_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd_data[7:4] == 4'd0) && (mode_rd_data[1:0] == 2'd0));
endmodule

bind irq_sense_front irq_sense_front_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags_o(flags_o), .lvl_sync(lvl_sync),
  .lvl_mask(lvl_mask), .hit_vec(hit_vec), .withdraw_o(withdraw_o),
  .cur_req_idx(cur_req_idx), .flag_rd_data(flag_rd_data), .mode_rd_data(mode_rd_data)
);

// File: tb/test_irq_sense_front.sv
`timescale 1ns/1ps
module test_irq_sense_front;
  localparam int N = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        flag_wr_en = 1'b0;
  logic [6:0]  flag_wr_idx = '0;
  logic [7:0]  flag_wr_data = '0;
  logic [6:0]  flag_rd_idx = '0;
  logic [7:0]  flag_rd_data;
  logic        ack_en = 1'b0;
  logic [6:0]  ack_idx = '0;
  logic        cur_req_valid = 1'b0;
  logic [6:0]  cur_req_idx = '0;
  logic        mode_wr_en = 1'b0;
  logic [4:0]  mode_wr_idx = '0;
  logic [7:0]  mode_wr_data = '0;
  logic [4:0]  mode_rd_idx = '0;
  logic [7:0]  mode_rd_data;
  logic [N-1:0] flags_o;
  logic        withdraw_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_sense_front i_irq_sense_front (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .flag_wr_en(flag_wr_en), .flag_wr_idx(flag_wr_idx), .flag_wr_data(flag_wr_data),
    .flag_rd_idx(flag_rd_idx), .flag_rd_data(flag_rd_data),
    .ack_en(ack_en), .ack_idx(ack_idx),
    .cur_req_valid(cur_req_valid), .cur_req_idx(cur_req_idx),
    .mode_wr_en(mode_wr_en), .mode_wr_idx(mode_wr_idx), .mode_wr_data(mode_wr_data),
    .mode_rd_idx(mode_rd_idx), .mode_rd_data(mode_rd_data),
    .flags_o(flags_o), .withdraw_o(withdraw_o)
  );

  // {mode[1:0], start level, new level, expected flag} for external source 70
  localparam logic [4:0] VEC [8] = '{
    {2'd1, 1'b1, 1'b0, 1'b1}, {2'd1, 1'b0, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1}, {2'd2, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b1}, {2'd3, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b1, 1'b1}, {2'd0, 1'b1, 1'b0, 1'b0}
  };

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_flag(int idx, logic [7:0] d);
    flag_wr_en = 1'b1; flag_wr_idx = 7'(idx); flag_wr_data = d;
    tick(1);
    flag_wr_en = 1'b0;
  endtask

  task automatic wr_mode(int off, logic [7:0] d);
    mode_wr_en = 1'b1; mode_wr_idx = 5'(off); mode_wr_data = d;
    tick(1);
    mode_wr_en = 1'b0;
  endtask

  task automatic do_ack(int idx);
    ack_en = 1'b1; ack_idx = 7'(idx);
    tick(1);
    ack_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    check("R1 flags", 32'(flags_o != '0), 0);
    mode_rd_idx = 5'd2; #0.1;
    check("R1 mode src66 level", 32'(mode_rd_data), 32'h00);
    mode_rd_idx = 5'd6; #0.1;
    check("R1 mode src70 rising", 32'(mode_rd_data), 32'h08);

    // R4 R3 table walk on source 70
    foreach (VEC[k]) begin
      wr_mode(6, {4'h0, VEC[k][4:3], 2'b00});
      irq_in[70] = VEC[k][2];
      tick(5);
      wr_flag(70, 8'h00);
      irq_in[70] = VEC[k][1];
      tick(4);
      check($sformatf("R4/R3 vector %0d", k), 32'(flags_o[70]), 32'(VEC[k][0]));
    end
    irq_in[70] = 1'b0;
    tick(4);

    // R2 latency on fixed rising source 5
    irq_in[5] = 1'b1;
    tick(2);
    check("R2 not yet", 32'(flags_o[5]), 0);
    tick(1);
    check("R2 third edge", 32'(flags_o[5]), 1);
    flag_rd_idx = 7'd5; #0.1;
    check("R10 flag read", 32'(flag_rd_data), 32'h01);
    wr_flag(5, 8'h01);
    check("R5 nonzero write ignored", 32'(flags_o[5]), 1);
    wr_flag(5, 8'h00);
    check("R5 zero write clears edge", 32'(flags_o[5]), 0);

    // R6 ack on edge source
    irq_in[5] = 1'b0; tick(4);
    irq_in[5] = 1'b1; tick(4);
    do_ack(5);
    check("R6 ack clears edge", 32'(flags_o[5]), 0);

    // R11 event beats same-cycle ack
    irq_in[5] = 1'b0; tick(4);
    irq_in[5] = 1'b1;
    tick(2);
    ack_en = 1'b1; ack_idx = 7'd5;
    tick(1);
    ack_en = 1'b0;
    check("R11 event wins over clear", 32'(flags_o[5]), 1);

    // R7 no withdraw for edge source
    cur_req_valid = 1'b1; cur_req_idx = 7'd5;
    irq_in[5] = 1'b0;
    tick(2);
    check("R7 no withdraw edge", 32'(withdraw_o), 0);

    // Fixed level source 3: R3 R5 R6 R7
    irq_in[3] = 1'b1; tick(4);
    check("R3 level set", 32'(flags_o[3]), 1);
    cur_req_idx = 7'd3;
    wr_flag(3, 8'h00);
    check("R5 level write ignored", 32'(flags_o[3]), 1);
    do_ack(3);
    check("R6 ack keeps level", 32'(flags_o[3]), 1);
    irq_in[3] = 1'b0;
    tick(2);
    check("R7 withdraw raised", 32'(withdraw_o), 1);
    tick(1);
    check("R7 withdraw done", 32'(withdraw_o), 0);
    check("R3 level cleared", 32'(flags_o[3]), 0);
    cur_req_valid = 1'b0;

    // R9 R8 mode change keeps pending flag on source 70
    wr_mode(6, 8'h08);
    tick(3);
    wr_flag(70, 8'h00);
    irq_in[70] = 1'b1; tick(4);
    check("R9 set before change", 32'(flags_o[70]), 1);
    wr_mode(6, 8'hF7);
    tick(2);
    check("R9 flag kept", 32'(flags_o[70]), 1);
    mode_rd_idx = 5'd6; #0.1;
    check("R8 only bits 3:2 stored", 32'(mode_rd_data), 32'h04);
    irq_in[70] = 1'b0; tick(4);
    wr_flag(70, 8'h00);
    irq_in[70] = 1'b1; tick(4);
    check("R8 falling mode ignores rise", 32'(flags_o[70]), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule